// File: doc/BRIEF.md
# Transceiver Register Initialization Sequencer

This block brings up a radio transceiver that is configured only through a write-only three-wire serial port. After a start strobe it sends nine 18-bit configuration words, one per register. Each word is assembled from small code fields on its input pins. These fields cover gain, filter bandwidth, linearity, PA bias, standby mode and charge-pump current. The band-select word also uses the tuned frequency, given in MHz. The low four bits of every word hold the target register address, and the payload sits above them.

Once the initial sequence has finished, the block pulses `done`. After that it accepts requests to resend one register, chosen by its address, using the field values present at that moment. Only one request is held while a word is on the wire. The serial port runs from the system clock. Each half-period of the serial clock lasts `SCLK_HALF` system clocks.

Top module: `xcvr_cfg_seq`

## Requirements
- R1: After reset `csN` is 1, `sclk` is 0 and `done` is 0. Nothing is sent until `start` is pulsed.
- R2: A `start` pulse while no sequence is running sends nine words with addresses 2, 5, 6, 7, 8, 9, 10, 11, 12, in that order. The address is carried in word bits [3:0]. A `start` that arrives while the sequence is running is ignored.
- R3: Each word is 18 bits long and is sent MSB first. `sdata` changes only while `sclk` falls, and the receiver samples it on the rising edge. Every high phase and every low phase of `sclk` lasts `SCLK_HALF` clocks.
- R4: `csN` falls exactly one clock before the first rising edge of `sclk`. It rises exactly one clock after the final falling edge. `sclk` is never high while `csN` is high.
- R5: Word 2 is modeSel<<17 | 1<<16 | 1<<6 | 1<<5 | 1<<4 | 2.
- R6: Word 5 is modeSel<<17 | 1<<16 | 1<<15 | 1<<11 | hi<<10 | cpCur<<9 | cpCur<<5 | five<<4 | 5. Here hi = (freqMhz > 5400) and five = (freqMhz > 3000).
- R7: Word 6 is 1<<14 | 6. Word 7 is rssiWide<<15 | txLpfBw<<9 | rxLpfBw<<7 | rxLpfFine<<4 | 7.
- R8: Word 8 is rxVgaSer<<16 | 1<<15 | 1<<14 | 1<<9 | 1<<4 | 8. Word 9 is txVgaSer<<14 | drvLin<<12 | vgaLin<<10 | upLin<<6 | bbGain<<4 | 9.
- R9: Word 10 is biasDelay<<10 | biasCode<<4 | 10.
- R10: Word 11 is rxGain<<4 | 11, and word 12 is txGain<<4 | 12.
- R11: `done` is high for exactly one clock. That clock is the one in which `csN` returns high after the ninth word. A single-register resend never raises `done`.
- R12: Once the sequence has completed, a `rewrReq` pulse with a valid `rewrAddr` (2 or 5 to 12) sends that one word. Requests with any other address, and requests made before the first sequence completes, produce no frame.
- R13: A request that arrives while a word is being sent is held and sent after that word. Only one request can be held: further requests that arrive while one is pending are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the full register sequence |
| rewrReq | input | 1 | Request a single-register resend |
| rewrAddr | input | 4 | Register address for the resend |
| freqMhz | input | FREQ_W | Tuned frequency in MHz |
| modeSel | input | 1 | Mode bit for standby and band words |
| cpCur | input | 1 | Charge-pump current select |
| rssiWide | input | 1 | Wide RSSI bandwidth select |
| txLpfBw | input | 2 | Transmit low-pass bandwidth code |
| rxLpfBw | input | 2 | Receive low-pass bandwidth code |
| rxLpfFine | input | 3 | Receive low-pass fine trim code |
| rxVgaSer | input | 1 | Receive VGA under serial control |
| txVgaSer | input | 1 | Transmit VGA under serial control |
| drvLin | input | 2 | Transmit driver linearity code |
| vgaLin | input | 2 | Transmit VGA linearity code |
| upLin | input | 2 | Upconverter linearity code |
| bbGain | input | 2 | Transmit baseband gain code |
| biasDelay | input | 4 | PA bias delay code |
| biasCode | input | 6 | PA bias current code |
| rxGain | input | 7 | Receive gain code |
| txGain | input | 6 | Transmit gain code |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low serial enable |
| sdata | output | 1 | Serial data, MSB first |
| done | output | 1 | One-cycle pulse when the sequence ends |

## Verification
The assertions check the frame shape on every cycle:
- `sclk` stays low outside a frame;
- data holds steady while `sclk` is high;
- there is exactly one lead clock and one tail clock around each frame;
- every frame carries eighteen rising edges;
- `done` is a single-cycle pulse that coincides with the release of `csN`.

The contents of each word can only be shown by the bench's scenarios, which decode every frame and compare it with layouts computed arithmetically. The same applies to:
- the order of the registers;
- the frequency thresholds around 3000 and 5400 MHz;
- the gain and bias sweeps;
- requests that are ignored, held or dropped.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int WORD_W   = 18;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 9;
  localparam int IDX_W    = 4;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic shift;
    logic release_;
  } seqStrobe_t;

  typedef struct packed {
    logic       modeSel;
    logic       cpCur;
    logic       rssiWide;
    logic [1:0] txLpfBw;
    logic [1:0] rxLpfBw;
    logic [2:0] rxLpfFine;
    logic       rxVgaSer;
    logic       txVgaSer;
    logic [1:0] drvLin;
    logic [1:0] vgaLin;
    logic [1:0] upLin;
    logic [1:0] bbGain;
    logic [3:0] biasDelay;
    logic [5:0] biasCode;
    logic [6:0] rxGain;
    logic [5:0] txGain;
  } cfgFields_t;

  // Sequence position to register address: 2, then 5..12
  function automatic logic [ADDR_W-1:0] seqAddr(input logic [IDX_W-1:0] idx);
    return (idx == '0) ? ADDR_W'(2) : ADDR_W'(idx + IDX_W'(4));
  endfunction

  function automatic logic addrValid(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(2)) || ((a >= ADDR_W'(5)) && (a <= ADDR_W'(12)));
  endfunction

endpackage

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              rewrReq,
  input  logic [ADDR_W-1:0] rewrAddr,
  output seqStrobe_t        strb,
  output logic [ADDR_W-1:0] loadAddr,
  output logic              done
);

  localparam int HC_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BC_W = $clog2(WORD_W);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(SCLK_HALF - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORD_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_TAIL} frameState_t;
  typedef enum logic [1:0] {P_WAIT, P_INIT, P_READY} phase_t;

  frameState_t       state;
  phase_t            phase;
  logic [IDX_W-1:0]  seqIdx;
  logic [HC_W-1:0]   halfCnt;
  logic [BC_W-1:0]   bitCnt;
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic              frameIsInit;
  logic              doneQ;
  logic              startOk;
  logic              halfEnd;
  logic              acceptReq;

  assign startOk   = start && (state == S_IDLE) && (phase != P_INIT);
  assign halfEnd   = (halfCnt == HC_LAST);
  assign acceptReq = rewrReq && (phase == P_READY) && addrValid(rewrAddr) && !pendValid;
  assign loadAddr  = (phase == P_INIT) ? seqAddr(seqIdx) : pendAddr;
  assign done      = doneQ;

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE:  strb.load = !startOk && ((phase == P_INIT) || ((phase == P_READY) && pendValid));
      S_LEAD:  strb.rise = 1'b1;
      S_HIGH: begin
        strb.fall  = halfEnd;
        strb.shift = halfEnd && (bitCnt != BC_LAST);
      end
      S_LOW:   strb.rise = halfEnd;
      S_TAIL:  strb.release_ = 1'b1;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      phase       <= P_WAIT;
      seqIdx      <= '0;
      halfCnt     <= '0;
      bitCnt      <= '0;
      pendValid   <= 1'b0;
      pendAddr    <= '0;
      frameIsInit <= 1'b0;
      doneQ       <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (acceptReq) begin
        pendValid <= 1'b1;
        pendAddr  <= rewrAddr;
      end
      case (state)
        S_IDLE: begin
          if (startOk) begin
            phase  <= P_INIT;
            seqIdx <= '0;
          end else if (strb.load) begin
            frameIsInit <= (phase == P_INIT);
            if (phase != P_INIT) pendValid <= 1'b0;
            state <= S_LEAD;
          end
        end
        S_LEAD: begin
          halfCnt <= '0;
          bitCnt  <= '0;
          state   <= S_HIGH;
        end
        S_HIGH: begin
          if (halfEnd) begin
            halfCnt <= '0;
            state   <= (bitCnt == BC_LAST) ? S_TAIL : S_LOW;
          end else begin
            halfCnt <= halfCnt + HC_W'(1);
          end
        end
        S_LOW: begin
          if (halfEnd) begin
            halfCnt <= '0;
            bitCnt  <= bitCnt + BC_W'(1);
            state   <= S_HIGH;
          end else begin
            halfCnt <= halfCnt + HC_W'(1);
          end
        end
        S_TAIL: begin
          state <= S_IDLE;
          if (frameIsInit) begin
            if (seqIdx == IDX_W'(NUM_REGS - 1)) begin
              phase <= P_READY;
              doneQ <= 1'b1;
            end else begin
              seqIdx <= seqIdx + IDX_W'(1);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_seq_dpath.sv
module cfg_seq_dpath
  import cfg_seq_pkg::*;
#(
  parameter int FREQ_W     = 14,
  parameter int HI_MHZ     = 5400,
  parameter int FIVEG_MHZ  = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] loadAddr,
  input  cfgFields_t        fld,
  input  logic [FREQ_W-1:0] freqMhz,
  output logic              sclk,
  output logic              csN,
  output logic              sdata
);

  logic              highBand;
  logic              fiveGig;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] shiftReg;

  assign highBand = (32'(freqMhz) > 32'(HI_MHZ));
  assign fiveGig  = (32'(freqMhz) > 32'(FIVEG_MHZ));

  always_comb begin
    word = '0;
    case (loadAddr)
      4'd2:  word = (WORD_W'(fld.modeSel) << 17) | (WORD_W'(1) << 16) | WORD_W'(7) << 4;
      4'd5:  word = (WORD_W'(fld.modeSel) << 17) | (WORD_W'(3) << 15) | (WORD_W'(1) << 11)
                  | (WORD_W'(highBand) << 10) | (WORD_W'(fld.cpCur) << 9)
                  | (WORD_W'(fld.cpCur) << 5) | (WORD_W'(fiveGig) << 4);
      4'd6:  word = WORD_W'(1) << 14;
      4'd7:  word = (WORD_W'(fld.rssiWide) << 15) | (WORD_W'(fld.txLpfBw) << 9)
                  | (WORD_W'(fld.rxLpfBw) << 7) | (WORD_W'(fld.rxLpfFine) << 4);
      4'd8:  word = (WORD_W'(fld.rxVgaSer) << 16) | (WORD_W'(3) << 14) | (WORD_W'(1) << 9)
                  | (WORD_W'(1) << 4);
      4'd9:  word = (WORD_W'(fld.txVgaSer) << 14) | (WORD_W'(fld.drvLin) << 12)
                  | (WORD_W'(fld.vgaLin) << 10) | (WORD_W'(fld.upLin) << 6)
                  | (WORD_W'(fld.bbGain) << 4);
      4'd10: word = (WORD_W'(fld.biasDelay) << 10) | (WORD_W'(fld.biasCode) << 4);
      4'd11: word = WORD_W'(fld.rxGain) << 4;
      4'd12: word = WORD_W'(fld.txGain) << 4;
      default: word = '0;
    endcase
    word = word | WORD_W'(loadAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
    end else begin
      if (strb.load) begin
        shiftReg <= word;
        csN      <= 1'b0;
      end else if (strb.shift) begin
        shiftReg <= shiftReg << 1;
      end
      if (strb.rise)     sclk <= 1'b1;
      if (strb.fall)     sclk <= 1'b0;
      if (strb.release_) csN  <= 1'b1;
    end
  end

  assign sdata = shiftReg[WORD_W-1];

endmodule

// File: rtl/xcvr_cfg_seq.sv
module xcvr_cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int SCLK_HALF = 2,
  parameter int FREQ_W    = 14,
  parameter int HI_MHZ    = 5400,
  parameter int FIVEG_MHZ = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              rewrReq,
  input  logic [3:0]        rewrAddr,
  input  logic [FREQ_W-1:0] freqMhz,
  input  logic              modeSel,
  input  logic              cpCur,
  input  logic              rssiWide,
  input  logic [1:0]        txLpfBw,
  input  logic [1:0]        rxLpfBw,
  input  logic [2:0]        rxLpfFine,
  input  logic              rxVgaSer,
  input  logic              txVgaSer,
  input  logic [1:0]        drvLin,
  input  logic [1:0]        vgaLin,
  input  logic [1:0]        upLin,
  input  logic [1:0]        bbGain,
  input  logic [3:0]        biasDelay,
  input  logic [5:0]        biasCode,
  input  logic [6:0]        rxGain,
  input  logic [5:0]        txGain,
  output logic              sclk,
  output logic              csN,
  output logic              sdata,
  output logic              done
);

  seqStrobe_t        strb;
  logic [ADDR_W-1:0] loadAddr;
  cfgFields_t        fld;

  assign fld = '{modeSel: modeSel, cpCur: cpCur, rssiWide: rssiWide, txLpfBw: txLpfBw,
                 rxLpfBw: rxLpfBw, rxLpfFine: rxLpfFine, rxVgaSer: rxVgaSer,
                 txVgaSer: txVgaSer, drvLin: drvLin, vgaLin: vgaLin, upLin: upLin,
                 bbGain: bbGain, biasDelay: biasDelay, biasCode: biasCode,
                 rxGain: rxGain, txGain: txGain};

  cfg_seq_ctrl #(.SCLK_HALF(SCLK_HALF)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rewrReq  (rewrReq),
    .rewrAddr (rewrAddr),
    .strb     (strb),
    .loadAddr (loadAddr),
    .done     (done)
  );

  cfg_seq_dpath #(.FREQ_W(FREQ_W), .HI_MHZ(HI_MHZ), .FIVEG_MHZ(FIVEG_MHZ)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadAddr (loadAddr),
    .fld      (fld),
    .freqMhz  (freqMhz),
    .sclk     (sclk),
    .csN      (csN),
    .sdata    (sdata)
  );

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
  import cfg_seq_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic csN,
  input logic sdata,
  input logic done
);

  logic       prevCs;
  logic       prevSclk;
  logic [5:0] riseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs   <= 1'b1;
      prevSclk <= 1'b0;
      riseCnt  <= '0;
    end else begin
      prevCs   <= csN;
      prevSclk <= sclk;
      if (prevCs && !csN)        riseCnt <= '0;
      else if (!prevSclk && sclk) riseCnt <= riseCnt + 6'd1;
    end
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN) sclk |-> !csN); // R4
  AST_LEAD_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN) $fell(csN) |=> sclk); // R4
  AST_TAIL_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (!$past(sclk) && $past(sclk, 2))); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN) sclk |-> $stable(sdata)); // R3
  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (!prevCs && csN) |-> (riseCnt == 6'(WORD_W))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R11
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN) done |-> $rose(csN)); // R11

endmodule

bind xcvr_cfg_seq cfg_seq_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .sclk  (sclk),
  .csN   (csN),
  .sdata (sdata),
  .done  (done)
);

// File: tb/xcvr_cfg_seq_tb.sv
`timescale 1ns/1ps
module xcvr_cfg_seq_tb;

  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        rewrReq = 1'b0;
  logic [3:0]  rewrAddr = '0;
  logic [13:0] freqMhz = 14'd2450;
  logic        modeSel = 1'b1, cpCur = 1'b0, rssiWide = 1'b0, rxVgaSer = 1'b1, txVgaSer = 1'b1;
  logic [1:0]  txLpfBw = 2'd1, rxLpfBw = 2'd1, drvLin = 2'd2, vgaLin = 2'd2, upLin = 2'd2, bbGain = 2'd0;
  logic [2:0]  rxLpfFine = 3'd2;
  logic [3:0]  biasDelay = 4'd15;
  logic [5:0]  biasCode = 6'd0;
  logic [6:0]  rxGain = 7'd64;
  logic [5:0]  txGain = 6'd32;
  logic        sclk, csN, sdata, done;

  int          nTests = 0, nFail = 0;
  int          frameCnt = 0, doneCnt = 0;
  logic [17:0] frames [0:511];

  always #4 clk = ~clk;

  xcvr_cfg_seq #(.SCLK_HALF(H)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .rewrReq(rewrReq), .rewrAddr(rewrAddr),
    .freqMhz(freqMhz), .modeSel(modeSel), .cpCur(cpCur), .rssiWide(rssiWide),
    .txLpfBw(txLpfBw), .rxLpfBw(rxLpfBw), .rxLpfFine(rxLpfFine), .rxVgaSer(rxVgaSer),
    .txVgaSer(txVgaSer), .drvLin(drvLin), .vgaLin(vgaLin), .upLin(upLin), .bbGain(bbGain),
    .biasDelay(biasDelay), .biasCode(biasCode), .rxGain(rxGain), .txGain(txGain),
    .sclk(sclk), .csN(csN), .sdata(sdata), .done(done)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] expWord(input logic [3:0] a);
    longint w;
    longint hi, five;
    hi   = (freqMhz > 14'd5400) ? 1 : 0;
    five = (freqMhz > 14'd3000) ? 1 : 0;
    case (a)
      4'd2:  w = modeSel * 131072 + 65536 + 64 + 32 + 16;
      4'd5:  w = modeSel * 131072 + 65536 + 32768 + 2048 + hi * 1024 + cpCur * 512 + cpCur * 32 + five * 16;
      4'd6:  w = 16384;
      4'd7:  w = rssiWide * 32768 + txLpfBw * 512 + rxLpfBw * 128 + rxLpfFine * 16;
      4'd8:  w = rxVgaSer * 65536 + 32768 + 16384 + 512 + 16;
      4'd9:  w = txVgaSer * 16384 + drvLin * 4096 + vgaLin * 1024 + upLin * 64 + bbGain * 16;
      4'd10: w = biasDelay * 1024 + biasCode * 16;
      4'd11: w = rxGain * 16;
      4'd12: w = txGain * 16;
      default: w = 0;
    endcase
    return 18'(w + a);
  endfunction

  // Serial monitor: decodes frames and checks edge timing
  longint cyc = 0, csFallCyc = 0, lastRise = 0, lastFall = 0;
  logic   prevCs = 1'b1, prevSclk = 1'b0, firstRise = 1'b0;
  logic [17:0] shiftW = '0;
  int     nBits = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevCs && !csN) begin
        shiftW = '0; nBits = 0; csFallCyc = cyc; firstRise = 1'b1;
      end
      if (!prevSclk && sclk) begin
        if (firstRise) chk(cyc - csFallCyc == 1, "R4 lead clock", cyc - csFallCyc, 1);
        else           chk(cyc - lastFall == H, "R3 low width", cyc - lastFall, H);
        firstRise = 1'b0;
        shiftW = {shiftW[16:0], sdata};
        nBits++;
        lastRise = cyc;
      end
      if (prevSclk && !sclk) begin
        chk(cyc - lastRise == H, "R3 high width", cyc - lastRise, H);
        lastFall = cyc;
      end
      if (!prevCs && csN) begin
        chk(cyc - lastFall == 1, "R4 tail clock", cyc - lastFall, 1);
        chk(nBits == 18, "R3 bit count", nBits, 18);
        if (frameCnt < 512) frames[frameCnt] = shiftW;
        frameCnt++;
      end
      if (sclk && csN) chk(1'b0, "R4 sclk outside frame", 1, 0);
      if (done) begin
        doneCnt++;
        chk(csN && !prevCs, "R11 done with release", {prevCs, csN}, 2'b01);
      end
      prevCs = csN;
      prevSclk = sclk;
    end
  end

  task automatic waitFrames(input int n, input int limit);
    for (int i = 0; i < limit && frameCnt < n; i++) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulseReq(input logic [3:0] a);
    @(negedge clk) begin rewrReq = 1'b1; rewrAddr = a; end
    @(negedge clk) rewrReq = 1'b0;
  endtask

  task automatic runInit(input string tag);
    int base, d0;
    base = frameCnt; d0 = doneCnt;
    pulseStart();
    waitFrames(base + 9, 2000);
    repeat (100) @(negedge clk);
    chk(frameCnt == base + 9, {tag, " R2 frame count"}, frameCnt - base, 9);
    chk(doneCnt == d0 + 1, {tag, " R11 done count"}, doneCnt - d0, 1);
    for (int i = 0; i < 9; i++) begin
      logic [3:0] a;
      a = (i == 0) ? 4'd2 : 4'(i + 4);
      chk(frames[base + i][3:0] == a, {tag, " R2 order"}, frames[base + i][3:0], a);
      chk(frames[base + i] == expWord(a), {tag, " R5-R10 word"}, frames[base + i], expWord(a));
    end
  endtask

  task automatic rewrite(input logic [3:0] a, input string tag);
    int base;
    base = frameCnt;
    pulseReq(a);
    waitFrames(base + 1, 300);
    chk(frameCnt == base + 1, {tag, " R12 one frame"}, frameCnt - base, 1);
    chk(frames[base] == expWord(a), tag, frames[base], expWord(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int base, d0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (50) @(negedge clk);
    chk(csN == 1'b1, "R1 csN idle", csN, 1);
    chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
    chk(done == 1'b0, "R1 done idle", done, 0);
    chk(frameCnt == 0, "R1 no frames", frameCnt, 0);

    // R12: rewrite before init is ignored
    pulseReq(4'd11);
    repeat (200) @(negedge clk);
    chk(frameCnt == 0, "R12 before init", frameCnt, 0);

    // Init with a second start mid-sequence (ignored, R2)
    base = frameCnt;
    pulseStart();
    repeat (200) @(negedge clk);
    pulseStart();
    waitFrames(base + 9, 2000);
    repeat (200) @(negedge clk);
    chk(frameCnt == base + 9, "R2 start ignored while running", frameCnt - base, 9);
    for (int i = 0; i < 9; i++) begin
      logic [3:0] a;
      a = (i == 0) ? 4'd2 : 4'(i + 4);
      chk(frames[base + i] == expWord(a), "R2 first run word", frames[base + i], expWord(a));
    end
    chk(doneCnt == 1, "R11 first done", doneCnt, 1);

    // Second pattern, rerun from ready
    modeSel = 1'b0; cpCur = 1'b1; rssiWide = 1'b1; txLpfBw = 2'd3; rxLpfBw = 2'd2; rxLpfFine = 3'd5;
    rxVgaSer = 1'b0; txVgaSer = 1'b0; drvLin = 2'd1; vgaLin = 2'd3; upLin = 2'd0; bbGain = 2'd3;
    biasDelay = 4'd9; biasCode = 6'd45; rxGain = 7'd127; txGain = 6'd63; freqMhz = 14'd5800;
    runInit("patB");

    d0 = doneCnt;
    // R6: band thresholds
    foreach (frames[k]) if (k < 1) begin end
    begin
      int fl [8] = '{100, 2999, 3000, 3001, 5399, 5400, 5401, 16383};
      for (int i = 0; i < 8; i++) begin
        freqMhz = 14'(fl[i]);
        cpCur = 1'(i);
        modeSel = 1'(i >> 1);
        rewrite(4'd5, "R6 band word");
      end
    end
    // R10 gain sweeps
    for (int g = 0; g < 128; g++) begin rxGain = 7'(g); rewrite(4'd11, "R10 rx gain"); end
    for (int g = 0; g < 64; g++)  begin txGain = 6'(g); rewrite(4'd12, "R10 tx gain"); end
    // R9 bias sweep
    for (int b = 0; b < 64; b++) begin biasCode = 6'(b); biasDelay = 4'(b); rewrite(4'd10, "R9 bias word"); end
    // R7, R8, R5 field sweeps
    for (int v = 0; v < 8; v++) begin
      rxLpfFine = 3'(v); txLpfBw = 2'(v); rxLpfBw = 2'(v >> 1); rssiWide = 1'(v >> 2);
      rewrite(4'd7, "R7 filter word");
      drvLin = 2'(v); vgaLin = 2'(v + 1); upLin = 2'(v >> 1); bbGain = 2'(v + 2); txVgaSer = 1'(v);
      rewrite(4'd9, "R8 linearity word");
      rxVgaSer = 1'(v); rewrite(4'd8, "R8 rssi word");
      modeSel = 1'(v); rewrite(4'd2, "R5 standby word");
    end
    rewrite(4'd6, "R7 cal word");
    chk(doneCnt == d0, "R11 no done on rewrite", doneCnt - d0, 0);

    // R12 invalid addresses
    begin
      logic [3:0] bad [7] = '{4'd0, 4'd1, 4'd3, 4'd4, 4'd13, 4'd14, 4'd15};
      for (int i = 0; i < 7; i++) begin
        base = frameCnt;
        pulseReq(bad[i]);
        repeat (150) @(negedge clk);
        chk(frameCnt == base, "R12 invalid address", frameCnt - base, 0);
      end
    end

    // R13 held and dropped requests
    base = frameCnt;
    rxGain = 7'd85; txGain = 6'd21;
    pulseReq(4'd11);
    repeat (10) @(negedge clk);
    pulseReq(4'd12);
    repeat (3) @(negedge clk);
    pulseReq(4'd9);
    repeat (400) @(negedge clk);
    chk(frameCnt == base + 2, "R13 frame count", frameCnt - base, 2);
    chk(frames[base] == expWord(4'd11), "R13 first word", frames[base], expWord(4'd11));
    chk(frames[base + 1] == expWord(4'd12), "R13 held word", frames[base + 1], expWord(4'd12));

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule